// File: doc/BRIEF.md
# SPI Slave Buffer Ownership Semaphore

This block arbitrates ownership of the transmit and receive buffers that a local CPU and an SPI slave engine share. Neither side may touch the buffers unless it holds the semaphore. The CPU asks for ownership with an acquire strobe and gives it up with a release strobe. The slave side is seen only through its chip-select line. Chip-select is resynchronised into the block clock domain, and its falling and rising edges mark the start and the end of a transaction. The slave takes the semaphore only when a transaction starts while the semaphore is free.

A CPU request that arrives while the slave holds the buffers is not refused. It is parked in a pending state, and ownership passes to the CPU as soon as the slave transaction ends. Two sticky event flags report that the CPU got ownership and that a granted transaction finished. An interrupt-enable mask with separate set and clear strobes feeds a single interrupt line. An optional shortcut turns every end event into an automatic acquire, so after each transaction the CPU owns the buffers without writing anything.

Top module: `bsem_top`

## Requirements
- R1: `status_o` encodes ownership as 0 = free, 1 = CPU, 2 = slave, 3 = slave with a CPU handover pending; `evt_o` bit 0 is the end event and bit 1 is the acquired event.
- R2: An `acq_i` pulse while free sets status to 1 and sets the acquired event on the next clock edge; when `acq_i` and a transaction start arrive together, the acquire wins.
- R3: An `acq_i` pulse while status is 1 keeps status at 1 and sets the acquired event again.
- R4: A `rel_i` pulse while status is 1 returns status to 0; `rel_i` in any other state changes nothing.
- R5: A falling edge on `cs_n_i` while free sets status to 2, visible CS_SYNC+1 clock edges after the edge is applied; a falling edge while status is 1 grants nothing.
- R6: The slave keeps status 2 while chip-select stays low; the rising edge of chip-select sets status to 0 and sets the end event. The end of a transaction that was never granted sets no event.
- R7: An `acq_i` pulse while status is 2 moves it to 3. In state 3, both `acq_i` and `rel_i` are ignored. The end of the transaction moves status to 1 and sets both the end and the acquired events.
- R8: While the shortcut is enabled (`short_we` with `short_wdata` = 1), the end of a granted transaction moves status directly to 1 and sets both events.
- R9: Events stay set until a `evt_clr_i` strobe is applied to their bit; a set in the same cycle as a clear wins.
- R10: `inten_set_we` ORs `inten_wdata` into the enable mask (bit 0 end, bit 1 acquired), and `inten_clr_we` removes those bits. `inten_rdata` returns the mask. `irq_o` is high when any set event has its enable bit set.
- R11: A synchronous active-low reset sets status to 0 and clears the events, the enable mask and the shortcut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acq_i | input | 1 | CPU acquire strobe |
| rel_i | input | 1 | CPU release strobe |
| cs_n_i | input | 1 | SPI chip-select, active low, asynchronous |
| evt_clr_i | input | 2 | Per-event clear strobes (bit 0 end, bit 1 acquired) |
| inten_set_we | input | 1 | Set strobe for the enable mask |
| inten_clr_we | input | 1 | Clear strobe for the enable mask |
| inten_wdata | input | 2 | Mask bits for a set or clear write |
| short_we | input | 1 | Write strobe for the shortcut enable |
| short_wdata | input | 1 | Value written to the shortcut enable |
| status_o | output | 2 | Ownership status |
| evt_o | output | 2 | Sticky event flags |
| inten_rdata | output | 2 | Current enable mask |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default of two chip-select synchroniser stages. The start and end edges therefore reach the state machine three clock edges late. The long delay lets a CPU acquire or release land between a chip-select edge and its grant or handover. The bench model carries its own delay line of length CS_SYNC+2, so those races are checked cycle by cycle. They include a release during a transaction that was never granted, and an acquire that arrives in the same cycle as the end edge.

// File: rtl/bsem_pkg.sv
package bsem_pkg;
  localparam int NEVT = 2;
  localparam int EVT_END = 0;
  localparam int EVT_ACQ = 1;

  typedef enum logic [1:0] {
    SEM_FREE = 2'd0,
    SEM_CPU  = 2'd1,
    SEM_SPI  = 2'd2,
    SEM_PEND = 2'd3
  } sem_state_e;

  function automatic logic [NEVT-1:0] mask_update(input logic [NEVT-1:0] cur,
                                                   input logic set_we,
                                                   input logic clr_we,
                                                   input logic [NEVT-1:0] wd);
    logic [NEVT-1:0] r;
    r = cur;
    if (clr_we) r = r & ~wd;
    if (set_we) r = r | wd;
    return r;
  endfunction

  function automatic logic [NEVT-1:0] sticky_update(input logic [NEVT-1:0] cur,
                                                     input logic [NEVT-1:0] set,
                                                     input logic [NEVT-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic any_pending(input logic [NEVT-1:0] evt,
                                       input logic [NEVT-1:0] en);
    return |(evt & en);
  endfunction
endpackage

// File: rtl/bsem_cs_sync.sv
module bsem_cs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  output logic start_o,
  output logic end_o
);
  logic [STAGES:0] chain;
  logic            cs_prev;

  assign chain[0] = cs_n_i;

  for (genvar g = 1; g <= STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain[g] <= 1'b1;
      else        chain[g] <= chain[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cs_prev <= 1'b1;
    else        cs_prev <= chain[STAGES];
  end

  assign start_o = cs_prev & ~chain[STAGES];
  assign end_o   = ~cs_prev & chain[STAGES];
endmodule

// File: rtl/bsem_fsm.sv
module bsem_fsm
  import bsem_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acq_i,
  input  logic       rel_i,
  input  logic       start_i,
  input  logic       end_i,
  input  logic       short_en_i,
  output sem_state_e state_o,
  output logic       acq_set_o,
  output logic       end_set_o
);
  sem_state_e st, nxt;

  always_comb begin
    nxt       = st;
    acq_set_o = 1'b0;
    end_set_o = 1'b0;
    unique case (st)
      SEM_FREE: begin
        if (acq_i) begin
          nxt       = SEM_CPU;
          acq_set_o = 1'b1;
        end else if (start_i) begin
          nxt = SEM_SPI;
        end
      end
      SEM_CPU: begin
        if (rel_i) begin
          nxt = SEM_FREE;
        end else if (acq_i) begin
          acq_set_o = 1'b1;
        end
      end
      SEM_SPI: begin
        if (end_i) begin
          end_set_o = 1'b1;
          if (acq_i || short_en_i) begin
            nxt       = SEM_CPU;
            acq_set_o = 1'b1;
          end else begin
            nxt = SEM_FREE;
          end
        end else if (acq_i) begin
          nxt = SEM_PEND;
        end
      end
      SEM_PEND: begin
        if (end_i) begin
          end_set_o = 1'b1;
          acq_set_o = 1'b1;
          nxt       = SEM_CPU;
        end
      end
      default: nxt = SEM_FREE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= SEM_FREE;
    else        st <= nxt;
  end

  assign state_o = st;
endmodule

// File: rtl/bsem_events.sv
module bsem_events
  import bsem_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acq_set_i,
  input  logic            end_set_i,
  input  logic [NEVT-1:0] evt_clr_i,
  input  logic            inten_set_we,
  input  logic            inten_clr_we,
  input  logic [NEVT-1:0] inten_wdata,
  input  logic            short_we,
  input  logic            short_wdata,
  output logic [NEVT-1:0] evt_o,
  output logic [NEVT-1:0] inten_o,
  output logic            short_en_o,
  output logic            irq_o
);
  logic [NEVT-1:0] evt_q, en_q, set_vec;
  logic            short_q;

  always_comb begin
    set_vec          = '0;
    set_vec[EVT_END] = end_set_i;
    set_vec[EVT_ACQ] = acq_set_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q   <= '0;
      en_q    <= '0;
      short_q <= 1'b0;
    end else begin
      evt_q <= sticky_update(evt_q, set_vec, evt_clr_i);
      en_q  <= mask_update(en_q, inten_set_we, inten_clr_we, inten_wdata);
      if (short_we) short_q <= short_wdata;
    end
  end

  assign evt_o      = evt_q;
  assign inten_o    = en_q;
  assign short_en_o = short_q;
  assign irq_o      = any_pending(evt_q, en_q);
endmodule

// File: rtl/bsem_top.sv
module bsem_top
  import bsem_pkg::*;
#(
  parameter int CS_SYNC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acq_i,
  input  logic            rel_i,
  input  logic            cs_n_i,
  input  logic [NEVT-1:0] evt_clr_i,
  input  logic            inten_set_we,
  input  logic            inten_clr_we,
  input  logic [NEVT-1:0] inten_wdata,
  input  logic            short_we,
  input  logic            short_wdata,
  output logic [1:0]      status_o,
  output logic [NEVT-1:0] evt_o,
  output logic [NEVT-1:0] inten_rdata,
  output logic            irq_o
);
  logic       start_w, end_w, short_en_w, acq_set_w, end_set_w;
  sem_state_e state_w;

  bsem_cs_sync #(.STAGES(CS_SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i),
    .start_o(start_w), .end_o(end_w)
  );

  bsem_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .acq_i(acq_i), .rel_i(rel_i),
    .start_i(start_w), .end_i(end_w), .short_en_i(short_en_w),
    .state_o(state_w), .acq_set_o(acq_set_w), .end_set_o(end_set_w)
  );

  bsem_events u_evt (
    .clk(clk), .rst_n(rst_n), .acq_set_i(acq_set_w), .end_set_i(end_set_w),
    .evt_clr_i(evt_clr_i), .inten_set_we(inten_set_we),
    .inten_clr_we(inten_clr_we), .inten_wdata(inten_wdata),
    .short_we(short_we), .short_wdata(short_wdata),
    .evt_o(evt_o), .inten_o(inten_rdata), .short_en_o(short_en_w),
    .irq_o(irq_o)
  );

  assign status_o = state_w;
endmodule

// File: rtl/bsem_checker.sv
module bsem_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       acq_i,
  input logic       rel_i,
  input logic       start_w,
  input logic       end_w,
  input logic [1:0] status,
  input logic [1:0] evt,
  input logic [1:0] clr
);
  p_free_acq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd0 && acq_i) |=> (status == 2'd1 && evt[1]));

  p_cpu_acq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd1 && acq_i && !rel_i) |=> (status == 2'd1 && evt[1]));

  p_cpu_rel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd1 && rel_i) |=> (status == 2'd0));

  p_free_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd0 && start_w && !acq_i) |=> (status == 2'd2));

  p_slave_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd2 && !end_w) |=> (status == 2'd2 || status == 2'd3));

  p_pend_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd3 && end_w) |=> (status == 2'd1 && evt == 2'b11));

  p_pend_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd3 && !end_w) |=> (status == 2'd3));

  p_end_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt[0] && !clr[0]) |=> evt[0]);

  p_acq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt[1] && !clr[1]) |=> evt[1]);
endmodule

bind bsem_top bsem_checker u_chk (
  .clk(clk), .rst_n(rst_n), .acq_i(acq_i), .rel_i(rel_i),
  .start_w(start_w), .end_w(end_w), .status(status_o),
  .evt(evt_o), .clr(evt_clr_i)
);

// File: tb/bsem_top_test.sv
module bsem_top_test;
  localparam int S = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acq_i = 0, rel_i = 0, cs_n_i = 1;
  logic [1:0] evt_clr_i = 0, inten_wdata = 0;
  logic inten_set_we = 0, inten_clr_we = 0, short_we = 0, short_wdata = 0;
  logic [1:0] status_o, evt_o, inten_rdata;
  logic irq_o;

  int n_chk = 0, n_fail = 0;

  // bench model
  logic [1:0] m_st = 0, m_evt = 0, m_en = 0;
  logic m_sh = 0;
  logic h [0:S+1];

  always #10 clk = ~clk;

  bsem_top #(.CS_SYNC(S)) uut (
    .clk(clk), .rst_n(rst_n), .acq_i(acq_i), .rel_i(rel_i), .cs_n_i(cs_n_i),
    .evt_clr_i(evt_clr_i), .inten_set_we(inten_set_we),
    .inten_clr_we(inten_clr_we), .inten_wdata(inten_wdata),
    .short_we(short_we), .short_wdata(short_wdata),
    .status_o(status_o), .evt_o(evt_o), .inten_rdata(inten_rdata),
    .irq_o(irq_o)
  );

  task automatic check(input string tag, input string what,
                       input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    logic st, en, ga, ge;
    logic [1:0] ns;
    for (int i = S + 1; i > 0; i--) h[i] = h[i-1];
    h[0] = cs_n_i;
    st = h[S+1] && !h[S];
    en = !h[S+1] && h[S];
    ns = m_st; ga = 0; ge = 0;
    if (m_st == 2'd0) begin
      if (acq_i) begin ns = 2'd1; ga = 1; end
      else if (st) ns = 2'd2;
    end else if (m_st == 2'd1) begin
      if (rel_i) ns = 2'd0;
      else if (acq_i) ga = 1;
    end else if (m_st == 2'd2) begin
      if (en) begin
        ge = 1;
        if (acq_i || m_sh) begin ns = 2'd1; ga = 1; end
        else ns = 2'd0;
      end else if (acq_i) ns = 2'd3;
    end else begin
      if (en) begin ns = 2'd1; ga = 1; ge = 1; end
    end
    m_st  = ns;
    m_evt = (m_evt & ~evt_clr_i) | {ga, ge};
    if (inten_clr_we) m_en = m_en & ~inten_wdata;
    if (inten_set_we) m_en = m_en | inten_wdata;
    if (short_we) m_sh = short_wdata;
  endtask

  task automatic compare(input string tag);
    check(tag, "status", status_o, m_st);
    check(tag, "evt", evt_o, m_evt);
    check(tag, "inten", inten_rdata, m_en);
    check(tag, "irq", {1'b0, irq_o}, {1'b0, |(m_evt & m_en)});
  endtask

  // drive at negedge, advance one posedge, compare at next negedge
  task automatic step(input string tag, input logic a, input logic r,
                      input logic cs, input logic [1:0] clr);
    acq_i = a; rel_i = r; cs_n_i = cs; evt_clr_i = clr;
    model_step();
    @(posedge clk); @(negedge clk);
    compare(tag);
    acq_i = 0; rel_i = 0; evt_clr_i = 0;
    inten_set_we = 0; inten_clr_we = 0; short_we = 0;
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, cs_n_i, 2'b00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i <= S + 1; i++) h[i] = 1'b1;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    check("R11", "status", status_o, 2'd0);
    check("R11", "evt", evt_o, 2'd0);
    check("R11", "inten", inten_rdata, 2'd0);
    check("R11", "irq", {1'b0, irq_o}, 2'd0);

    // R2 / R1: acquire from free
    step("R2", 1, 0, 1, 2'b00);
    check("R1", "status cpu", status_o, 2'd1);
    check("R2", "acq evt", evt_o, 2'b10);
    // R3: clear, then acquire again while CPU-owned
    step("R9", 0, 0, 1, 2'b10);
    check("R9", "cleared", evt_o, 2'b00);
    step("R3", 1, 0, 1, 2'b00);
    check("R3", "status kept", status_o, 2'd1);
    check("R3", "acq again", evt_o, 2'b10);
    // R5: start while CPU-owned is not granted
    step("R5", 0, 0, 0, 2'b10);
    idle("R5", S + 2);
    check("R5", "no grant", status_o, 2'd1);
    // R4: release; R6: end of ungranted transaction raises nothing
    step("R4", 0, 1, 0, 2'b00);
    check("R4", "free", status_o, 2'd0);
    step("R6", 0, 0, 1, 2'b00);
    idle("R6", S + 2);
    check("R6", "no end evt", evt_o, 2'b00);
    step("R4", 0, 1, 1, 2'b00);
    check("R4", "rel ignored", status_o, 2'd0);

    // R5: grant to slave, latency S+1
    step("R5", 0, 0, 0, 2'b00);
    idle("R5", S - 1);
    check("R5", "not yet", status_o, 2'd0);
    idle("R5", 1);
    check("R5", "slave", status_o, 2'd2);
    // R7: pending handover
    step("R7", 1, 0, 0, 2'b00);
    check("R7", "pending", status_o, 2'd3);
    step("R7", 0, 1, 0, 2'b00);
    check("R7", "rel ignored", status_o, 2'd3);
    step("R7", 0, 0, 1, 2'b00);
    idle("R7", S);
    check("R7", "handover", status_o, 2'd1);
    check("R7", "both evts", evt_o, 2'b11);

    // R6: plain slave transaction
    step("R6", 0, 1, 1, 2'b11);
    step("R6", 0, 0, 0, 2'b00);
    idle("R6", S + 3);
    check("R6", "slave holds", status_o, 2'd2);
    step("R6", 0, 0, 1, 2'b00);
    idle("R6", S);
    check("R6", "free after end", status_o, 2'd0);
    check("R6", "end evt", evt_o, 2'b01);

    // R10: enables and irq
    inten_set_we = 1; inten_wdata = 2'b11;
    step("R10", 0, 0, 1, 2'b00);
    check("R10", "mask", inten_rdata, 2'b11);
    check("R10", "irq", {1'b0, irq_o}, 2'd1);
    inten_clr_we = 1; inten_wdata = 2'b01;
    step("R10", 0, 0, 1, 2'b00);
    check("R10", "mask clr", inten_rdata, 2'b10);
    check("R10", "irq off", {1'b0, irq_o}, 2'd0);

    // R8: shortcut
    short_we = 1; short_wdata = 1;
    step("R8", 0, 0, 1, 2'b01);
    step("R8", 0, 0, 0, 2'b00);
    idle("R8", S + 1);
    step("R8", 0, 0, 1, 2'b00);
    idle("R8", S);
    check("R8", "cpu via short", status_o, 2'd1);
    check("R8", "evts", evt_o, 2'b11);
    short_we = 1; short_wdata = 0;
    step("R8", 0, 1, 1, 2'b11);

    // R9: set wins over clear in same cycle
    step("R9", 1, 0, 1, 2'b10);
    check("R9", "set wins", evt_o, 2'b10);

    // random phase
    for (int t = 0; t < 3000; t++) begin
      logic a, r, c;
      logic [1:0] cl;
      a  = ($urandom % 9) == 0;
      r  = ($urandom % 7) == 0;
      c  = (($urandom % 8) == 0) ? ~cs_n_i : cs_n_i;
      cl = (($urandom % 5) == 0) ? 2'($urandom) : 2'b00;
      if (($urandom % 20) == 0) begin inten_set_we = 1; inten_wdata = 2'($urandom); end
      if (($urandom % 20) == 0) begin inten_clr_we = 1; inten_wdata = 2'($urandom); end
      if (($urandom % 40) == 0) begin short_we = 1; short_wdata = 1'($urandom); end
      step("R1", a, r, c, cl);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule